// File: doc/BRIEF.md
# Three-format instruction decoder

This block turns one 16-bit instruction word of a small 32-bit processor into the control fields that the rest of the pipeline needs. The two most significant bits of the word pick one of three layouts. The first is a two-register layout with a 7-bit opcode. The second is a short layout with a register and an 8-bit unsigned constant. The third is a conditional branch layout with a 4-bit condition and a 10-bit signed halfword offset.

The decoder reports several things about each word. It gives the operation class and the register indices. It gives the short constant, or for a branch the condition and the byte offset. It says whether the word touches data memory, in which direction and at which width. It gives the full instruction length in bytes, which tells fetch whether a 32-bit extension word follows. It also reports whether the word is illegal. It holds no processor state. The parameter `OUT_REG` selects either a purely combinational path or a single output register stage.

Top module: `insn_dec3`

## Requirements
- R1: `fmt_o` is 0 when bit 15 is 0, 1 when bits 15:14 are 2'b10, and 2 when they are 2'b11. In layout 0, `ra_o` is bits 7:4 and `rb_o` is bits 3:0. Outside layout 0, `rb_o` is 0.
- R2: In layout 1, `ra_o` is bits 11:8 and `imm8_o` is bits 7:0. Sub-codes 0 and 1 in bits 13:12 (add or subtract the constant) give class ALU (1). Sub-codes 2 and 3 (read or write the special register that the constant selects) give class SREG (8). In every other layout `imm8_o` is 0.
- R3: In layout 2, `br_cond_o` is bits 13:10 and `br_off_o` is `{bits 9:0, 1'b0}`, an 11-bit two's-complement byte offset. Conditions 0 to 9 give class BRANCH (4). Conditions 10 to 15 are illegal. Outside layout 2, both fields are 0.
- R4: `len_o` is 6 for layout-0 opcodes 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30 and 0x36 to 0x39. It is 2 for every other word.
- R5: Loads (`mem_rd_o`) are 0x07, 0x08, 0x0A, 0x0C at word size, 0x21, 0x22, 0x38 at half size, and 0x1C, 0x1D, 0x36 at byte size. Stores (`mem_wr_o`) are 0x06, 0x09, 0x0B, 0x0D at word size, 0x23, 0x24, 0x39 at half size, and 0x1E, 0x1F, 0x37 at byte size. `mem_size_o` is 0 for byte, 1 for half and 2 for word, and it is 0 when there is no access. Narrow loads are zero-extended by the consumer.
- R6: `shift_o` is 1 only for the shift opcodes 0x27, 0x28 and 0x2D. It tells the consumer to use the low 5 bits of register B as the shift amount.
- R7: Layout-0 opcodes 0x0F to 0x18 and 0x3A to 0x7F are illegal. On every illegal word, `illegal_o` is 1, the class is TRAP (9), there is no memory access, `shift_o` is 0 and `len_o` is 2.
- R8: The layout-0 classes are as follows:
  - NOP (0): 0x00
  - ALU (1): 0x01, 0x02, 0x05, 0x0E, 0x1B, 0x20 and 0x26 to 0x34, except 0x30
  - LOAD (2) and STORE (3): as listed in R5
  - CALL (5): 0x03, 0x19
  - RET (6): 0x04
  - JUMP (7): 0x1A, 0x25
  - TRAP (9): 0x30, 0x35
- R9: With `OUT_REG`=1, the outputs change one clock edge after the word, and they do not change between edges. While `rst_ni` is low, the outputs read class 0, layout 0, length 2, and every other field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock for the optional output stage |
| rst_ni | input | 1 | asynchronous reset, active low |
| insn_i | input | 16 | instruction word |
| cls_o | output | 4 | operation class code |
| fmt_o | output | 2 | layout code |
| ra_o | output | 4 | first register index |
| rb_o | output | 4 | second register index |
| imm8_o | output | 8 | short unsigned constant |
| br_cond_o | output | 4 | branch condition |
| br_off_o | output | 11 | signed branch byte offset |
| mem_rd_o | output | 1 | data load |
| mem_wr_o | output | 1 | data store |
| mem_size_o | output | 2 | access width code |
| shift_o | output | 1 | shift amount comes from register B |
| len_o | output | 3 | instruction length in bytes |
| illegal_o | output | 1 | illegal word |

## Verification
An exhaustive sweep of all 65536 words compares every output field against a table model in the bench. This separates each defined opcode from its undefined neighbours, each long form from its short twin, and each legal branch condition from the reserved ones. A run of seeded random words changes every field from cycle to cycle, which would expose stale or cross-wired register stage contents. Directed words check the reset values and show that a new word does not reach the outputs before the next clock edge.

// File: rtl/insn_dec3_pkg.sv
package insn_dec3_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned RIDX_W = 4;
  localparam int unsigned IMM_W  = 8;
  localparam int unsigned COND_W = 4;
  localparam int unsigned OFF_W  = 11;
  localparam int unsigned LEN_W  = 3;
  localparam int unsigned NCOND  = 10;

  typedef enum logic [3:0] {
    CL_NOP = 4'd0, CL_ALU = 4'd1, CL_LOAD = 4'd2, CL_STORE = 4'd3, CL_BRANCH = 4'd4,
    CL_CALL = 4'd5, CL_RET = 4'd6, CL_JUMP = 4'd7, CL_SREG = 4'd8, CL_TRAP = 4'd9
  } cls_e;

  typedef enum logic [1:0] {FMT_REG = 2'd0, FMT_IMM = 2'd1, FMT_BR = 2'd2} fmt_e;
  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2} msize_e;

  typedef struct packed {
    cls_e               cls;
    fmt_e               fmt;
    logic [RIDX_W-1:0]  ra;
    logic [RIDX_W-1:0]  rb;
    logic [IMM_W-1:0]   imm8;
    logic [COND_W-1:0]  cond;
    logic [OFF_W-1:0]   off;
    logic               rd;
    logic               wr;
    msize_e             size;
    logic               shift;
    logic [LEN_W-1:0]   len;
    logic               illegal;
  } dec_t;

  localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(2);
  localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(6);

  function automatic dec_t dec_idle();
    dec_t d;
    d = '0;
    d.cls = CL_NOP;
    d.fmt = FMT_REG;
    d.size = SZ_B;
    d.len = LEN_SHORT;
    return d;
  endfunction

  function automatic dec_t mark_illegal(dec_t d_in);
    dec_t d;
    d = d_in;
    d.cls = CL_TRAP;
    d.illegal = 1'b1;
    d.rd = 1'b0;
    d.wr = 1'b0;
    d.size = SZ_B;
    d.shift = 1'b0;
    d.len = LEN_SHORT;
    return d;
  endfunction
endpackage

// File: rtl/insn_dec3_regfmt.sv
module insn_dec3_regfmt
  import insn_dec3_pkg::*;
(
  input  logic [14:0] word_i,
  output dec_t        dec_o
);
  logic [6:0] op;
  assign op = word_i[14:8];

  function automatic dec_t mem_op(dec_t d_in, logic is_wr, msize_e sz, logic lng);
    dec_t d;
    d = d_in;
    d.cls = is_wr ? CL_STORE : CL_LOAD;
    d.rd = !is_wr;
    d.wr = is_wr;
    d.size = sz;
    d.len = lng ? LEN_LONG : LEN_SHORT;
    return d;
  endfunction

  always_comb begin
    dec_t d;
    d = dec_idle();
    d.fmt = FMT_REG;
    d.ra = word_i[7:4];
    d.rb = word_i[3:0];
    case (op)
      7'h00: d.cls = CL_NOP;
      7'h01, 7'h1B, 7'h20: begin d.cls = CL_ALU; d.len = LEN_LONG; end
      7'h02, 7'h05, 7'h0E, 7'h26, 7'h29, 7'h2A, 7'h2B, 7'h2C, 7'h2E, 7'h2F,
      7'h31, 7'h32, 7'h33, 7'h34: d.cls = CL_ALU;
      7'h27, 7'h28, 7'h2D: begin d.cls = CL_ALU; d.shift = 1'b1; end
      7'h03: begin d.cls = CL_CALL; d.len = LEN_LONG; end
      7'h19: d.cls = CL_CALL;
      7'h04: d.cls = CL_RET;
      7'h1A: begin d.cls = CL_JUMP; d.len = LEN_LONG; end
      7'h25: d.cls = CL_JUMP;
      7'h30: begin d.cls = CL_TRAP; d.len = LEN_LONG; end
      7'h35: d.cls = CL_TRAP;
      // loads
      7'h07, 7'h0A: d = mem_op(d, 1'b0, SZ_W, 1'b0);
      7'h08, 7'h0C: d = mem_op(d, 1'b0, SZ_W, 1'b1);
      7'h21:        d = mem_op(d, 1'b0, SZ_H, 1'b0);
      7'h22, 7'h38: d = mem_op(d, 1'b0, SZ_H, 1'b1);
      7'h1C:        d = mem_op(d, 1'b0, SZ_B, 1'b0);
      7'h1D, 7'h36: d = mem_op(d, 1'b0, SZ_B, 1'b1);
      // stores
      7'h06, 7'h0B: d = mem_op(d, 1'b1, SZ_W, 1'b0);
      7'h09, 7'h0D: d = mem_op(d, 1'b1, SZ_W, 1'b1);
      7'h23:        d = mem_op(d, 1'b1, SZ_H, 1'b0);
      7'h24, 7'h39: d = mem_op(d, 1'b1, SZ_H, 1'b1);
      7'h1E:        d = mem_op(d, 1'b1, SZ_B, 1'b0);
      7'h1F, 7'h37: d = mem_op(d, 1'b1, SZ_B, 1'b1);
      default:      d = mark_illegal(d);
    endcase
    dec_o = d;
  end
endmodule

// File: rtl/insn_dec3_immfmt.sv
module insn_dec3_immfmt
  import insn_dec3_pkg::*;
(
  input  logic [13:0] word_i,
  output dec_t        dec_o
);
  always_comb begin
    dec_t d;
    d = dec_idle();
    d.fmt = FMT_IMM;
    d.ra = word_i[11:8];
    d.imm8 = word_i[7:0];
    // sub-codes 0,1: add/sub constant; 2,3: special register read/write
    d.cls = word_i[13] ? CL_SREG : CL_ALU;
    dec_o = d;
  end
endmodule

// File: rtl/insn_dec3_brfmt.sv
module insn_dec3_brfmt
  import insn_dec3_pkg::*;
(
  input  logic [13:0] word_i,
  output dec_t        dec_o
);
  logic [COND_W-1:0] cond;
  assign cond = word_i[13:10];

  always_comb begin
    dec_t d;
    d = dec_idle();
    d.fmt = FMT_BR;
    d.cond = cond;
    d.off = {word_i[9:0], 1'b0};
    d.cls = CL_BRANCH;
    if (32'(cond) >= NCOND) d = mark_illegal(d);
    dec_o = d;
  end
endmodule

// File: rtl/insn_dec3.sv
module insn_dec3
  import insn_dec3_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [WORD_W-1:0]     insn_i,
  output logic [3:0]            cls_o,
  output logic [1:0]            fmt_o,
  output logic [RIDX_W-1:0]     ra_o,
  output logic [RIDX_W-1:0]     rb_o,
  output logic [IMM_W-1:0]      imm8_o,
  output logic [COND_W-1:0]     br_cond_o,
  output logic [OFF_W-1:0]      br_off_o,
  output logic                  mem_rd_o,
  output logic                  mem_wr_o,
  output logic [1:0]            mem_size_o,
  output logic                  shift_o,
  output logic [LEN_W-1:0]      len_o,
  output logic                  illegal_o
);
  dec_t d_reg, d_imm, d_br, d_sel, d_q;

  insn_dec3_regfmt u_regfmt (.word_i(insn_i[14:0]), .dec_o(d_reg));
  insn_dec3_immfmt u_immfmt (.word_i(insn_i[13:0]), .dec_o(d_imm));
  insn_dec3_brfmt  u_brfmt  (.word_i(insn_i[13:0]), .dec_o(d_br));

  always_comb begin
    if (!insn_i[15])     d_sel = d_reg;
    else if (!insn_i[14]) d_sel = d_imm;
    else                 d_sel = d_br;
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) d_q <= dec_idle();
        else         d_q <= d_sel;
      end
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign d_q = d_sel;
    end
  endgenerate

  assign cls_o      = d_q.cls;
  assign fmt_o      = d_q.fmt;
  assign ra_o       = d_q.ra;
  assign rb_o       = d_q.rb;
  assign imm8_o     = d_q.imm8;
  assign br_cond_o  = d_q.cond;
  assign br_off_o   = d_q.off;
  assign mem_rd_o   = d_q.rd;
  assign mem_wr_o   = d_q.wr;
  assign mem_size_o = d_q.size;
  assign shift_o    = d_q.shift;
  assign len_o      = d_q.len;
  assign illegal_o  = d_q.illegal;
endmodule

// File: rtl/insn_dec3_chk.sv
module insn_dec3_chk
  import insn_dec3_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] insn_i,
  input logic [3:0]        cls_o,
  input logic [1:0]        fmt_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic              shift_o,
  input logic [LEN_W-1:0]  len_o,
  input logic              illegal_o
);
  logic primed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  a_r5_rd_wr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  a_r4_len_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_o == LEN_SHORT) || (len_o == LEN_LONG));

  a_r7_illegal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!mem_rd_o && !mem_wr_o && !shift_o && len_o == LEN_SHORT && cls_o == CL_TRAP));

  a_r3_branch_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_o == CL_BRANCH) |-> (len_o == LEN_SHORT && fmt_o == FMT_BR && !illegal_o));

  a_r6_shift_alu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o |-> (cls_o == CL_ALU && fmt_o == FMT_REG));

  generate
    if (OUT_REG) begin : g_seq
      a_r2_imm_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed_q && $past(insn_i[15:14]) == 2'b10) |-> (cls_o == CL_ALU || cls_o == CL_SREG));
    end else begin : g_cmb
      a_r2_imm_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (insn_i[15:14] == 2'b10) |-> (cls_o == CL_ALU || cls_o == CL_SREG));
    end
  endgenerate
endmodule

bind insn_dec3 insn_dec3_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .insn_i(insn_i), .cls_o(cls_o), .fmt_o(fmt_o),
  .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .shift_o(shift_o), .len_o(len_o),
  .illegal_o(illegal_o)
);

// File: tb/insn_dec3_test.sv
`timescale 1ns/1ps
module insn_dec3_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [15:0] insn = 16'h0000;
  logic [3:0] cls_o, ra_o, rb_o, br_cond_o;
  logic [1:0] fmt_o, mem_size_o;
  logic [7:0] imm8_o;
  logic [10:0] br_off_o;
  logic mem_rd_o, mem_wr_o, shift_o, illegal_o;
  logic [2:0] len_o;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  bit bad;

  always #5 clk = ~clk;

  insn_dec3 #(.OUT_REG(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .insn_i(insn), .cls_o(cls_o), .fmt_o(fmt_o),
    .ra_o(ra_o), .rb_o(rb_o), .imm8_o(imm8_o), .br_cond_o(br_cond_o), .br_off_o(br_off_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_size_o(mem_size_o), .shift_o(shift_o),
    .len_o(len_o), .illegal_o(illegal_o)
  );

  typedef struct {
    int cls, fmt, ra, rb, imm, cond, off, rd, wr, sz, sh, len, ill;
  } exp_t;

  function automatic exp_t model(logic [15:0] w);
    exp_t e;
    logic [7:0] op;
    e = '{cls:0, fmt:0, ra:0, rb:0, imm:0, cond:0, off:0, rd:0, wr:0, sz:0, sh:0, len:2, ill:0};
    op = w[15:8];
    if (!w[15]) begin
      e.ra = int'(w[7:4]); e.rb = int'(w[3:0]);
      if (op inside {8'h01,8'h03,8'h08,8'h09,8'h0C,8'h0D,8'h1A,8'h1B,8'h1D,8'h1F,
                     8'h20,8'h22,8'h24,8'h30,8'h36,8'h37,8'h38,8'h39}) e.len = 6;
      if (op inside {8'h07,8'h08,8'h0A,8'h0C}) begin e.rd = 1; e.sz = 2; e.cls = 2; end
      else if (op inside {8'h21,8'h22,8'h38}) begin e.rd = 1; e.sz = 1; e.cls = 2; end
      else if (op inside {8'h1C,8'h1D,8'h36}) begin e.rd = 1; e.sz = 0; e.cls = 2; end
      else if (op inside {8'h06,8'h09,8'h0B,8'h0D}) begin e.wr = 1; e.sz = 2; e.cls = 3; end
      else if (op inside {8'h23,8'h24,8'h39}) begin e.wr = 1; e.sz = 1; e.cls = 3; end
      else if (op inside {8'h1E,8'h1F,8'h37}) begin e.wr = 1; e.sz = 0; e.cls = 3; end
      else if (op == 8'h00) e.cls = 0;
      else if (op inside {8'h01,8'h02,8'h05,8'h0E,8'h1B,8'h20,[8'h26:8'h2F],[8'h31:8'h34]}) begin
        e.cls = 1;
        e.sh = (op inside {8'h27,8'h28,8'h2D}) ? 1 : 0;
      end
      else if (op inside {8'h03,8'h19}) e.cls = 5;
      else if (op == 8'h04) e.cls = 6;
      else if (op inside {8'h1A,8'h25}) e.cls = 7;
      else if (op inside {8'h30,8'h35}) e.cls = 9;
      else begin e.ill = 1; e.cls = 9; e.len = 2; end
    end else if (!w[14]) begin
      e.fmt = 1; e.ra = int'(w[11:8]); e.imm = int'(w[7:0]);
      e.cls = (w[13:12] < 2'd2) ? 1 : 8;
    end else begin
      e.fmt = 2; e.cond = int'(w[13:10]); e.off = int'({w[9:0], 1'b0});
      if (w[13:10] > 4'd9) begin e.ill = 1; e.cls = 9; end
      else e.cls = 4;
    end
    return e;
  endfunction

  task automatic fld(string tag, string name, int act, int exp, logic [15:0] w);
    if (act != exp) begin
      bad = 1'b1;
      $display("FAIL %s %s word=%h actual=%0d expected=%0d", tag, name, w, act, exp);
    end
  endtask

  task automatic compare(logic [15:0] w);
    exp_t e;
    string ctag;
    e = model(w);
    bad = 1'b0;
    ctag = e.ill ? "R7" : (e.fmt == 1 ? "R2" : (e.fmt == 2 ? "R3" : "R8"));
    fld("R1", "fmt", int'(fmt_o), e.fmt, w);
    fld("R1", "ra", int'(ra_o), e.ra, w);
    fld("R1", "rb", int'(rb_o), e.rb, w);
    fld("R2", "imm8", int'(imm8_o), e.imm, w);
    fld("R3", "cond", int'(br_cond_o), e.cond, w);
    fld("R3", "off", int'(br_off_o), e.off, w);
    fld("R4", "len", int'(len_o), e.len, w);
    fld("R5", "rd", int'(mem_rd_o), e.rd, w);
    fld("R5", "wr", int'(mem_wr_o), e.wr, w);
    fld("R5", "size", int'(mem_size_o), e.sz, w);
    fld("R6", "shift", int'(shift_o), e.sh, w);
    fld("R7", "illegal", int'(illegal_o), e.ill, w);
    fld(ctag, "class", int'(cls_o), e.cls, w);
    vectors++;
    if (bad) fails++;
  endtask

  task automatic apply(logic [15:0] w);
    insn = w;
    @(negedge clk);
    compare(w);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1789));
    insn = 16'h2A5F;
    repeat (2) @(negedge clk);
    // R9: reset values while rst_ni low
    bad = 1'b0;
    fld("R9", "rst class", int'(cls_o), 0, insn);
    fld("R9", "rst len", int'(len_o), 2, insn);
    fld("R9", "rst ra", int'(ra_o), 0, insn);
    fld("R9", "rst rd", int'(mem_rd_o), 0, insn);
    fld("R9", "rst illegal", int'(illegal_o), 0, insn);
    vectors++;
    if (bad) fails++;
    rst_ni = 1'b1;
    @(negedge clk);

    // R9: new word not visible before the next edge
    apply(16'h0100);
    insn = 16'h0200;
    #2;
    bad = 1'b0;
    fld("R9", "hold len", int'(len_o), 6, insn);
    vectors++;
    if (bad) fails++;
    @(negedge clk);
    compare(16'h0200);

    // directed corners across formats
    apply(16'h8000);  // R2 add constant, reg 0
    apply(16'hB3FF);  // R2 write special register
    apply(16'hE7FE);  // R3 cond 9, negative offset
    apply(16'hE800);  // R3 cond 10 illegal
    apply(16'h2712);  // R6 shift
    apply(16'h3A00);  // R7 first upper hole
    apply(16'h0F44);  // R7 lower hole
    apply(16'h39AB);  // R4 R5 half store long

    // exhaustive sweep
    for (int i = 0; i < 65536; i++) apply(16'(i));

    // seeded random words
    for (int i = 0; i < 3000; i++) apply(16'($urandom()));

    finish_run();
  end
endmodule